// File: doc/BRIEF.md
# Trimming Egress Queue with Congestion NACK

This block sits at the egress of a switch port and holds packets until the port can send them. Packets arrive as a word stream marked with start and end flags. When the first word of a packet arrives, the block reads the packet's length from its header and decides what to do with it. If the main buffer has enough unreserved space, the whole packet is queued. If it does not, the payload is cut away. Only the fixed-size header is kept, marked as trimmed and with its length rewritten, and it is queued in a small side queue.

The side queue is served with strict priority at packet boundaries. The congestion signal therefore reaches the destination ahead of any waiting bulk traffic. If the side queue is also full, the packet is discarded completely and a counter records it.

A receive-side checker watches the outgoing stream. For each trimmed header it raises a negative-acknowledgement request carrying that header's sequence number on the next cycle. No timeout is involved. A trimmed header signals congestion and does not signal a lost path.

Top module: `trimq_egress`

## Requirements
- R1: A packet whose header length field (word 0, bits 30:20, in words) is no larger than the main buffer's unreserved space at its start word is forwarded complete and unchanged.
- R2: A packet that does not fit while the header queue has room for one header is forwarded as its first HDR_WORDS words only (16 by default). Word 0 has bit 31 set to 1 and bits 30:20 rewritten to HDR_WORDS. All other header bits, including the sequence number in bits 15:0, are unchanged. The last kept word carries the end flag.
- R3: A packet that fits neither queue produces no output words, and the drop count rises by exactly one.
- R4: At each packet boundary, a complete trimmed header waiting in the side queue is sent before any waiting full packet. A packet already started is never interrupted.
- R5: Output packets are contiguous from start to end. Full packets leave in arrival order, and trimmed headers leave in arrival order.
- R6: When the start word of a trimmed header is accepted at the output, the NACK output pulses one cycle later with that header's bits 15:0. Full packets raise no NACK.
- R7: While output valid is high and output ready is low, output valid and data hold steady.
- R8: After reset, output valid, NACK valid and the drop count are all zero.
- R9: Space is reserved for the whole packet when it is admitted and returned word by word as words leave. Each decision therefore depends on that packet's own length, and a shorter later packet can still be admitted after a longer one was trimmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word present |
| in_sop | input | 1 | First word of a packet |
| in_eop | input | 1 | Last word of a packet |
| in_data | input | DATA_W | Input word; word 0 holds trim flag, length and sequence |
| out_ready | input | 1 | Port can take a word |
| out_valid | output | 1 | Output word present |
| out_sop | output | 1 | First output word of a packet |
| out_eop | output | 1 | Last output word of a packet |
| out_data | output | DATA_W | Output word |
| nack_valid | output | 1 | Retransmission request pulse |
| nack_seq | output | 16 | Sequence number being requested |
| drop_cnt | output | CNT_W | Packets discarded entirely |

## Verification
A directed sequence runs with the output stalled. One packet is admitted, a larger one is trimmed, and a smaller one is then admitted. A further large packet is trimmed and a last one is dropped. When the output is released, the resulting output order separates strict priority from plain arrival order, and per-length admission from any sticky full state. Seeded random traffic then mixes packet lengths from just above the header size to well past it with random stalls and idle gaps. Every output packet must match its generated content either exactly or in its trimmed form, and the output classes must stay ordered. Trimmed outputs, complete outputs and drops together must account for every packet sent, and each trimmed header must be matched by a NACK.

// File: rtl/trimq_pkg.sv
package trimq_pkg;
  localparam int FLAG_BIT = 31;
  localparam int LEN_LSB  = 20;
  localparam int LEN_W    = 11;
  localparam int SEQ_W    = 16;

  typedef enum logic [1:0] {SRC_NONE, SRC_HDR, SRC_MAIN} src_e;
  typedef enum logic [1:0] {W_IDLE, W_KEEP, W_TRIM, W_DROP} wmode_e;
endpackage

// File: rtl/trimq_fifo.sv
module trimq_fifo #(
  parameter int W     = 33,
  parameter int DEPTH = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [W-1:0]      wr_data,
  input  logic              rd_en,
  output logic [W-1:0]      rd_data,
  output logic [$clog2(DEPTH):0] level
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr] <= wr_data;
  end

  assign rd_data = mem[rptr];

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (wr_en) wptr <= wptr + 1'b1;
      if (rd_en) rptr <= rptr + 1'b1;
      level <= level + (AW+1)'(wr_en) - (AW+1)'(rd_en);
    end
  end

  a_r9_no_overflow: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (level < (AW+1)'(DEPTH)));
  a_r5_no_underflow: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> (level != '0));
endmodule

// File: rtl/trimq_admit.sv
module trimq_admit
  import trimq_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int MAIN_DEPTH = 64,
  parameter int HDR_WORDS  = 16,
  parameter int HQ_DEPTH   = 32,
  parameter int CNT_W      = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         in_valid,
  input  logic                         in_sop,
  input  logic                         in_eop,
  input  logic [DATA_W-1:0]            in_data,
  input  logic                         main_pop,
  input  logic [$clog2(HQ_DEPTH):0]    hq_level,
  output logic                         main_wr,
  output logic                         hdr_wr,
  output logic [DATA_W:0]              wr_entry,
  output logic [CNT_W-1:0]             drop_cnt
);
  localparam int RW = $clog2(MAIN_DEPTH) + 1;
  localparam int IW = $clog2(HDR_WORDS) + 1;

  wmode_e        mode, cur_mode;
  logic [IW-1:0] hcnt, idx;
  logic [RW-1:0] resv;
  logic [LEN_W-1:0] len;
  logic [31:0]   main_free, hq_free;
  logic          start;
  logic [DATA_W-1:0] wdata;
  logic          weop;

  assign len       = in_data[LEN_LSB +: LEN_W];
  assign start     = in_valid && in_sop;
  assign main_free = 32'(MAIN_DEPTH) - 32'(resv);
  assign hq_free   = 32'(HQ_DEPTH) - 32'(hq_level);
  assign idx       = start ? '0 : hcnt;

  always_comb begin
    cur_mode = mode;
    if (start) begin
      if (main_free >= 32'(len))                cur_mode = W_KEEP;
      else if (hq_free >= 32'(HDR_WORDS))       cur_mode = W_TRIM;
      else                                      cur_mode = W_DROP;
    end
  end

  always_comb begin
    wdata = in_data;
    if (cur_mode == W_TRIM && idx == '0) begin
      wdata[FLAG_BIT]            = 1'b1;
      wdata[LEN_LSB +: LEN_W]    = LEN_W'(HDR_WORDS);
    end
    weop = (cur_mode == W_TRIM) ? (idx == IW'(HDR_WORDS - 1)) : in_eop;
  end

  assign main_wr  = in_valid && cur_mode == W_KEEP;
  assign hdr_wr   = in_valid && cur_mode == W_TRIM && idx < IW'(HDR_WORDS);
  assign wr_entry = {weop, wdata};

  always_ff @(posedge clk) begin
    if (rst) begin
      mode     <= W_IDLE;
      hcnt     <= '0;
      resv     <= '0;
      drop_cnt <= '0;
    end else begin
      if (in_valid) begin
        mode <= in_eop ? W_IDLE : cur_mode;
        hcnt <= in_eop ? '0 : ((idx < IW'(HDR_WORDS)) ? idx + 1'b1 : idx);
      end
      resv <= resv + ((start && cur_mode == W_KEEP) ? RW'(len) : '0)
                   - RW'(main_pop);
      if (start && cur_mode == W_DROP) drop_cnt <= drop_cnt + 1'b1;
    end
  end

  a_r3_drop_step: assert property (@(posedge clk) disable iff (rst)
    (drop_cnt != $past(drop_cnt)) |-> (drop_cnt == $past(drop_cnt) + 1'b1));
endmodule

// File: rtl/trimq_sched.sv
module trimq_sched
  import trimq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PW     = 8,
  parameter int LW     = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              main_eop_wr,
  input  logic              hdr_eop_wr,
  input  logic [DATA_W:0]   main_rd,
  input  logic [DATA_W:0]   hdr_rd,
  input  logic [LW-1:0]     main_level,
  input  logic              out_ready,
  output logic              main_pop,
  output logic              hdr_pop,
  output logic              out_valid,
  output logic              out_sop,
  output logic              out_eop,
  output logic [DATA_W-1:0] out_data
);
  src_e          cur, sel;
  logic [PW-1:0] main_pkts, hdr_pkts;
  logic          load;
  logic [DATA_W:0] word;

  assign load = !out_valid || out_ready;

  always_comb begin
    if (cur != SRC_NONE)      sel = cur;
    else if (hdr_pkts != '0)  sel = SRC_HDR;
    else if (main_pkts != '0) sel = SRC_MAIN;
    else                      sel = SRC_NONE;
  end

  assign word     = (sel == SRC_HDR) ? hdr_rd : main_rd;
  assign hdr_pop  = load && sel == SRC_HDR;
  assign main_pop = load && sel == SRC_MAIN;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur       <= SRC_NONE;
      out_valid <= 1'b0;
      out_sop   <= 1'b0;
      out_eop   <= 1'b0;
      out_data  <= '0;
      main_pkts <= '0;
      hdr_pkts  <= '0;
    end else begin
      if (load) begin
        out_valid <= sel != SRC_NONE;
        if (sel != SRC_NONE) begin
          out_data <= word[DATA_W-1:0];
          out_sop  <= cur == SRC_NONE;
          out_eop  <= word[DATA_W];
          cur      <= word[DATA_W] ? SRC_NONE : sel;
        end
      end
      main_pkts <= main_pkts + PW'(main_eop_wr) - PW'(main_pop && main_rd[DATA_W]);
      hdr_pkts  <= hdr_pkts + PW'(hdr_eop_wr) - PW'(hdr_pop && hdr_rd[DATA_W]);
    end
  end

  a_r7_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_sop)));
  a_r5_whole_pkt: assert property (@(posedge clk) disable iff (rst)
    main_pop |-> (main_level != '0));
  a_r4_one_source: assert property (@(posedge clk) disable iff (rst)
    $onehot0({main_pop, hdr_pop}));
endmodule

// File: rtl/trimq_nack.sv
module trimq_nack #(
  parameter int SEQ_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hs,
  input  logic             hs_sop,
  input  logic             hs_flag,
  input  logic [SEQ_W-1:0] hs_seq,
  output logic             nack_valid,
  output logic [SEQ_W-1:0] nack_seq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      nack_valid <= 1'b0;
      nack_seq   <= '0;
    end else begin
      nack_valid <= hs && hs_sop && hs_flag;
      if (hs && hs_sop && hs_flag) nack_seq <= hs_seq;
    end
  end

  a_r6_nack_follows: assert property (@(posedge clk) disable iff (rst)
    (hs && hs_sop && hs_flag) |=> (nack_valid && nack_seq == $past(hs_seq)));
  a_r6_no_false_nack: assert property (@(posedge clk) disable iff (rst)
    !(hs && hs_sop && hs_flag) |=> !nack_valid);
endmodule

// File: rtl/trimq_egress.sv
module trimq_egress
  import trimq_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int MAIN_DEPTH = 64,
  parameter int HDR_WORDS  = 16,
  parameter int HQ_HDRS    = 2,
  parameter int CNT_W      = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic [DATA_W-1:0] in_data,
  input  logic              out_ready,
  output logic              out_valid,
  output logic              out_sop,
  output logic              out_eop,
  output logic [DATA_W-1:0] out_data,
  output logic              nack_valid,
  output logic [15:0]       nack_seq,
  output logic [CNT_W-1:0]  drop_cnt
);
  localparam int HQ_DEPTH = HQ_HDRS * HDR_WORDS;
  localparam int MLW      = $clog2(MAIN_DEPTH) + 1;
  localparam int HLW      = $clog2(HQ_DEPTH) + 1;
  localparam int PW       = MLW + 1;

  logic            main_wr, hdr_wr, main_pop, hdr_pop;
  logic [DATA_W:0] wr_entry, main_rd, hdr_rd;
  logic [MLW-1:0]  main_level;
  logic [HLW-1:0]  hq_level;

  trimq_admit #(
    .DATA_W(DATA_W), .MAIN_DEPTH(MAIN_DEPTH), .HDR_WORDS(HDR_WORDS),
    .HQ_DEPTH(HQ_DEPTH), .CNT_W(CNT_W)
  ) admit_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
    .in_data(in_data), .main_pop(main_pop), .hq_level(hq_level),
    .main_wr(main_wr), .hdr_wr(hdr_wr), .wr_entry(wr_entry), .drop_cnt(drop_cnt)
  );

  trimq_fifo #(.W(DATA_W + 1), .DEPTH(MAIN_DEPTH)) main_q (
    .clk(clk), .rst(rst), .wr_en(main_wr), .wr_data(wr_entry),
    .rd_en(main_pop), .rd_data(main_rd), .level(main_level)
  );

  trimq_fifo #(.W(DATA_W + 1), .DEPTH(HQ_DEPTH)) hdr_q (
    .clk(clk), .rst(rst), .wr_en(hdr_wr), .wr_data(wr_entry),
    .rd_en(hdr_pop), .rd_data(hdr_rd), .level(hq_level)
  );

  trimq_sched #(.DATA_W(DATA_W), .PW(PW), .LW(MLW)) sched_i (
    .clk(clk), .rst(rst),
    .main_eop_wr(main_wr && wr_entry[DATA_W]),
    .hdr_eop_wr(hdr_wr && wr_entry[DATA_W]),
    .main_rd(main_rd), .hdr_rd(hdr_rd), .main_level(main_level),
    .out_ready(out_ready), .main_pop(main_pop), .hdr_pop(hdr_pop),
    .out_valid(out_valid), .out_sop(out_sop), .out_eop(out_eop), .out_data(out_data)
  );

  trimq_nack #(.SEQ_W(SEQ_W)) nack_i (
    .clk(clk), .rst(rst), .hs(out_valid && out_ready), .hs_sop(out_sop),
    .hs_flag(out_data[FLAG_BIT]), .hs_seq(out_data[SEQ_W-1:0]),
    .nack_valid(nack_valid), .nack_seq(nack_seq)
  );
endmodule

// File: tb/trimq_egress_tb_top.sv
module trimq_egress_tb_top;
  localparam int HW = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
  logic [31:0] in_data = '0;
  logic        out_ready = 1'b0;
  logic        out_valid, out_sop, out_eop, nack_valid;
  logic [31:0] out_data;
  logic [15:0] nack_seq, drop_cnt;

  int checks = 0, fails = 0;
  int sent = 0, full_seen = 0, trim_seen = 0, nacks = 0;
  int last_full = -1, last_trim = -1;
  int sent_len [0:255];
  int ord_seq [0:15];
  int ord_trim [0:15];
  int ord_n = 0;
  logic [31:0] rx [0:63];
  int rx_n = 0;
  logic prev_hold = 0, prev_nack = 0;
  logic [31:0] prev_data = '0;
  logic [15:0] prev_seq = '0;
  bit done = 0;

  always #10 clk = ~clk;

  trimq_egress dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
    .in_data(in_data), .out_ready(out_ready), .out_valid(out_valid), .out_sop(out_sop),
    .out_eop(out_eop), .out_data(out_data), .nack_valid(nack_valid),
    .nack_seq(nack_seq), .drop_cnt(drop_cnt)
  );

  function automatic logic [31:0] pkt_word(int seq, int len, int i);
    if (i == 0) return {1'b0, 11'(len), 4'h0, 16'(seq)};
    return {8'(seq), 8'(i), 16'hA5C3 ^ 16'(seq)};
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_pkt(int seq, int len, int gap);
    sent_len[seq] = len;
    sent++;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1; in_sop = (i == 0); in_eop = (i == len - 1);
      in_data = pkt_word(seq, len, i);
    end
    @(negedge clk);
    in_valid = 0; in_sop = 0; in_eop = 0;
    for (int g = 0; g < gap; g++) @(negedge clk);
  endtask

  task automatic eval_pkt();
    int seq;
    bit trimmed;
    seq = int'(rx[0][15:0]);
    trimmed = rx[0][31];
    if (ord_n < 16) begin ord_seq[ord_n] = seq; ord_trim[ord_n] = int'(trimmed); end
    ord_n++;
    if (trimmed) begin
      trim_seen++;
      check(rx_n == HW, "R2 trimmed length", 32'(rx_n), 32'(HW));
      check(rx[0] == {1'b1, 11'(HW), 4'h0, 16'(seq)}, "R2 header rewrite",
            rx[0], {1'b1, 11'(HW), 4'h0, 16'(seq)});
      for (int i = 1; i < HW && i < rx_n; i++)
        check(rx[i] == pkt_word(seq, 0, i), "R2 header word", rx[i], pkt_word(seq, 0, i));
      check(seq > last_trim, "R5 trimmed order", 32'(seq), 32'(last_trim + 1));
      last_trim = seq;
    end else begin
      full_seen++;
      check(rx_n == sent_len[seq], "R1 full length", 32'(rx_n), 32'(sent_len[seq]));
      for (int i = 0; i < rx_n; i++)
        check(rx[i] == pkt_word(seq, sent_len[seq], i), "R1 payload word",
              rx[i], pkt_word(seq, sent_len[seq], i));
      check(seq > last_full, "R5 full order", 32'(seq), 32'(last_full + 1));
      last_full = seq;
    end
  endtask

  // Monitor: samples mid-cycle, reflecting the coming clock edge
  always begin
    @(negedge clk); #5;
    if (!rst) begin
      if (prev_hold)
        check(out_valid && out_data == prev_data, "R7 hold while stalled", out_data, prev_data);
      if (prev_nack || nack_valid) begin
        check(nack_valid == prev_nack, "R6 nack pulse", 32'(nack_valid), 32'(prev_nack));
        if (prev_nack) check(nack_seq == prev_seq, "R6 nack seq", 32'(nack_seq), 32'(prev_seq));
      end
      if (nack_valid) nacks++;
      prev_hold = out_valid && !out_ready;
      prev_data = out_data;
      prev_nack = out_valid && out_ready && out_sop && out_data[31];
      prev_seq  = out_data[15:0];
      if (out_valid && out_ready) begin
        if (out_sop) begin
          check(rx_n == 0, "R5 contiguous packet", 32'(rx_n), 32'd0);
          rx_n = 0;
        end
        if (rx_n < 64) rx[rx_n] = out_data;
        rx_n++;
        if (out_eop) begin eval_pkt(); rx_n = 0; end
      end
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
    end
  end

  initial begin
    int unused;
    unused = $urandom(32'h5eed);
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(!out_valid, "R8 reset out_valid", 32'(out_valid), 0);
    check(!nack_valid, "R8 reset nack_valid", 32'(nack_valid), 0);
    check(drop_cnt == 0, "R8 reset drop_cnt", 32'(drop_cnt), 0);

    // Directed: stalled output, fill and overflow (R1 R2 R3 R4 R9)
    out_ready = 0;
    send_pkt(1, 40, 0);
    send_pkt(2, 32, 0);
    send_pkt(3, 20, 0);
    send_pkt(4, 32, 0);
    send_pkt(5, 30, 2);
    check(drop_cnt == 1, "R3 drop count", 32'(drop_cnt), 1);
    out_ready = 1;
    repeat (200) @(negedge clk);
    check(ord_n == 4, "R3 dropped packet absent", 32'(ord_n), 4);
    check(ord_seq[0] == 1 && ord_trim[0] == 0, "R4 started packet finishes", 32'(ord_seq[0]), 1);
    check(ord_seq[1] == 2 && ord_trim[1] == 1, "R4 header first", 32'(ord_seq[1]), 2);
    check(ord_seq[2] == 4 && ord_trim[2] == 1, "R4 second header", 32'(ord_seq[2]), 4);
    check(ord_seq[3] == 3 && ord_trim[3] == 0, "R9 short packet admitted", 32'(ord_seq[3]), 3);
    check(nacks == 2, "R6 nack count directed", 32'(nacks), 2);

    // Random traffic with random stalls
    for (int s = 10; s < 150; s++) begin
      out_ready = ($urandom_range(0, 9) < 6);
      send_pkt(s, $urandom_range(HW + 1, 60), $urandom_range(0, 3));
    end
    out_ready = 1;
    repeat (400) @(negedge clk);
    check(32'(drop_cnt) == 32'(sent - full_seen - trim_seen), "R3 drops account",
          32'(drop_cnt), 32'(sent - full_seen - trim_seen));
    check(nacks == trim_seen, "R6 nack per trimmed header", 32'(nacks), 32'(trim_seen));
    check(!out_valid, "R5 queue drained", 32'(out_valid), 0);
    done = 1;
    summary();
  end
endmodule